// File: doc/BRIEF.md
# Time-Multiplexed Delay Reservoir Core

This core is a reservoir computer built from one nonlinear node and a digital feedback delay line. Each input sample accepted from the stream port is held while the core walks through `NODES` virtual-node slots, one slot per clock. In each slot the held sample is scaled by an input gain and given a per-node sign from a configured mask. It is then added to a scaled value taken from the delay line, and clipped to a programmable symmetric limit. The clipped value is written back into the delay line. The delay line holds `NODES+1` words, so it is one slot longer than the hold period. Each virtual node therefore couples to its neighbour from the previous sample rather than to itself.

The same clipped value is also multiplied by a per-node readout weight and summed. One slot after the last node of a sample, the core presents the saturated weighted sum on a valid-only output. Software or a neighbouring block loads the gains, clip limit, mask bits and weights through a plain write port. The port only takes writes while the core is idle.

Back-pressure rules: `in_ready` is high only while the core is idle. A sample is taken on a rising edge where `in_valid` and `in_ready` are both high. The upstream side may hold `in_valid` high at any time, and nothing is taken while `in_ready` is low. The output has no ready: each result is a single-cycle pulse that the consumer must capture.

Top module: `tdr_reservoir_core`

## Requirements
- R1: `in_ready` is high whenever the core is idle. After the edge that accepts a sample it is low for exactly `NODES` cycles, then high again.
- R2: `out_valid` is a one-cycle pulse that rises on the `NODES`-th rising edge after the accepting edge, which is one cycle after the last node slot. Exactly one result is produced per accepted sample, in acceptance order.
- R3: For node n of a sample u, the value before clipping is floor(fb·p/2^15) + s·floor(eta·u/2^15). Here p is the fed-back value, s is +1 when mask bit n is 0 and −1 when it is 1, and all operands are signed Q1.15.
- R4: The value fed back into a slot is the node value produced `NODES+1` slots earlier, in the continuous slot order across samples. Slots with no such predecessor since reset read zero.
- R5: Each node value is clipped to [−L, +L]. L is the 15-bit magnitude written with select 2 from `cfg_data[14:0]`.
- R6: A feedback gain written with select 1 is clamped to [−FB_LIMIT, +FB_LIMIT] before it is stored. A gain of 1.0 or more in magnitude can never be applied.
- R7: The output equals floor(Σ w_n·x_n / 2^15) over the `NODES` node values of the sample, saturated to the signed 16-bit range.
- R8: Configuration writes (`cfg_wr` high at a rising edge) have no effect unless the core is idle. Select 0 writes eta, 1 the feedback gain, 2 the clip limit, 3 mask bit `cfg_idx` from `cfg_data[0]`, and 4 weight `cfg_idx`. Other selects are ignored.
- R9: After synchronous reset `in_ready` is 1, `out_valid` and `out_data` are 0, and the delay line is zero. Eta, feedback gain, mask and weights are zero, and the clip limit is 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Core idle and able to take a sample |
| in_data | input | W | Input sample, signed Q1.15 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select |
| cfg_idx | input | IDX_W | Node index for mask and weight writes |
| cfg_data | input | W | Configuration value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | W | Readout result, signed Q1.15 |

## Verification
A first run with a non-trivial mask and weights of alternating sign, using a short run of equal samples, separates correct neighbour coupling through the `NODES+1` delay from a delay of `NODES` or a self-loop. A following run of zero samples shows the feedback path alone decaying. Full-scale positive and negative inputs against a small clip limit and a near-unity feedback gain separate the node clip from the feedback clamp, and all-maximum weights drive the readout into both saturation rails. Configuration writes issued mid-sample, followed by samples computed with the old settings, show that writes during busy periods are dropped.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

  typedef enum logic [2:0] {
    SEL_ETA    = 3'd0,
    SEL_FB     = 3'd1,
    SEL_CLIP   = 3'd2,
    SEL_MASK   = 3'd3,
    SEL_WEIGHT = 3'd4
  } cfg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/tdr_cfg_regs.sv
module tdr_cfg_regs #(
  parameter int NODES    = 8,
  parameter int W        = 16,
  parameter int FB_LIMIT = 31744,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       idle,
  input  logic                       cfg_wr,
  input  logic [2:0]                 cfg_sel,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [W-1:0]               cfg_data,
  output logic signed [W-1:0]        eta_q,
  output logic signed [W-1:0]        fb_q,
  output logic signed [W-1:0]        clip_q,
  output logic [NODES-1:0]           mask_q,
  output logic [NODES-1:0][W-1:0]    w_q
);
  import tdr_pkg::*;

  localparam logic signed [W-1:0] FB_HI = W'(FB_LIMIT);
  localparam logic signed [W-1:0] FB_LO = -FB_HI;

  logic              wr_ok;
  logic signed [W-1:0] fb_clamped;
  logic              idx_ok;

  assign wr_ok  = cfg_wr && idle;
  assign idx_ok = (int'(cfg_idx) < NODES);

  always_comb begin
    if ($signed(cfg_data) > FB_HI)      fb_clamped = FB_HI;
    else if ($signed(cfg_data) < FB_LO) fb_clamped = FB_LO;
    else                                fb_clamped = $signed(cfg_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eta_q  <= '0;
      fb_q   <= '0;
      clip_q <= {1'b0, {(W-1){1'b1}}};
      mask_q <= '0;
      w_q    <= '0;
    end else if (wr_ok) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_ETA:  eta_q  <= $signed(cfg_data);
        SEL_FB:   fb_q   <= fb_clamped;
        SEL_CLIP: clip_q <= {1'b0, cfg_data[W-2:0]};
        SEL_MASK: if (idx_ok) mask_q[cfg_idx] <= cfg_data[0];
        SEL_WEIGHT: if (idx_ok) w_q[cfg_idx] <= cfg_data;
        default: ;
      endcase
    end
  end

  AST_FB_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_q <= FB_HI) && (fb_q >= FB_LO)); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(idle) |-> ($stable(eta_q) && $stable(fb_q) && $stable(clip_q)
                      && $stable(mask_q) && $stable(w_q))); // R8

endmodule

// File: rtl/tdr_delay_ring.sv
module tdr_delay_ring #(
  parameter int DEPTH = 9,
  parameter int W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic signed [W-1:0] wr_data,
  output logic signed [W-1:0] rd_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic signed [W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wr_ptr;
  logic [PTR_W-1:0]    rd_ptr;

  // The word read in a slot is the oldest one, i.e. the one about to be
  // replaced, so the read pointer sits on the write pointer.
  assign rd_ptr  = wr_ptr;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (adv) begin
      mem[wr_ptr] <= wr_data;
      wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end
  end

  AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wr_ptr == LAST) |=> (wr_ptr == '0)); // R4

  AST_RD_IS_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(rd_data)); // R4

endmodule

// File: rtl/tdr_node.sv
module tdr_node #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] prev,
  input  logic signed [W-1:0] sample,
  input  logic signed [W-1:0] eta,
  input  logic signed [W-1:0] fb,
  input  logic signed [W-1:0] clip,
  input  logic                neg,
  output logic signed [W-1:0] x
);
  localparam int FRAC = W - 1;
  localparam int PW   = 2 * W;
  localparam int SW   = W + 3;

  logic signed [PW-1:0] fb_prod;
  logic signed [PW-1:0] in_prod;
  logic signed [SW-1:0] fb_term;
  logic signed [SW-1:0] in_term;
  logic signed [SW-1:0] masked;
  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] lim_hi;
  logic signed [SW-1:0] lim_lo;

  always_comb begin
    fb_prod = fb * prev;
    in_prod = eta * sample;
    fb_term = SW'(fb_prod >>> FRAC);
    in_term = SW'(in_prod >>> FRAC);
    masked  = neg ? -in_term : in_term;
    sum     = fb_term + masked;
    lim_hi  = SW'(clip);
    lim_lo  = -lim_hi;
    if (sum > lim_hi)      x = clip;
    else if (sum < lim_lo) x = W'(lim_lo);
    else                   x = W'(sum);
  end

endmodule

// File: rtl/tdr_readout.sv
module tdr_readout #(
  parameter int NODES = 8,
  parameter int W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                first,
  input  logic                last,
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] weight,
  output logic                out_valid,
  output logic [W-1:0]        out_data
);
  localparam int FRAC  = W - 1;
  localparam int ACC_W = 2 * W + $clog2(NODES) + 1;
  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((1 << (W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_MIN = -Y_MAX - 1;

  logic signed [2*W-1:0]  prod;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] scaled;
  logic [W-1:0]            y_sat;

  always_comb begin
    prod   = x * weight;
    sum    = (first ? '0 : acc) + ACC_W'(prod);
    scaled = sum >>> FRAC;
    if (scaled > Y_MAX)      y_sat = W'(Y_MAX);
    else if (scaled < Y_MIN) y_sat = W'(Y_MIN);
    else                     y_sat = W'(scaled);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= step && last;
      if (step) begin
        acc <= sum;
        if (last) out_data <= y_sat;
      end
    end
  end

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && last) |=> $stable(out_data)); // R7

endmodule

// File: rtl/tdr_reservoir_core.sv
module tdr_reservoir_core #(
  parameter int NODES    = 8,
  parameter int W        = 16,
  parameter int FB_LIMIT = 31744,
  localparam int IDX_W   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_sel,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [W-1:0]     cfg_data,
  output logic             out_valid,
  output logic [W-1:0]     out_data
);
  import tdr_pkg::*;

  localparam int DEPTH = NODES + 1;
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NODES - 1);

  seq_state_e          state;
  logic [IDX_W-1:0]    slot;
  logic signed [W-1:0] u_hold;
  logic                accept;
  logic                step;
  logic                first;
  logic                last;

  logic signed [W-1:0]     eta_q, fb_q, clip_q;
  logic [NODES-1:0]        mask_q;
  logic [NODES-1:0][W-1:0] w_q;
  logic signed [W-1:0]     fed_back;
  logic signed [W-1:0]     node_x;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign step     = (state == ST_RUN);
  assign first    = (slot == '0);
  assign last     = (slot == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      slot   <= '0;
      u_hold <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_RUN;
          slot   <= '0;
          u_hold <= $signed(in_data);
        end
        ST_RUN: begin
          slot <= last ? '0 : slot + 1'b1;
          if (last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  tdr_cfg_regs #(
    .NODES(NODES), .W(W), .FB_LIMIT(FB_LIMIT), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .idle(in_ready),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .eta_q(eta_q), .fb_q(fb_q), .clip_q(clip_q), .mask_q(mask_q), .w_q(w_q)
  );

  tdr_delay_ring #(.DEPTH(DEPTH), .W(W)) u_ring (
    .clk(clk), .rst_n(rst_n), .adv(step), .wr_data(node_x), .rd_data(fed_back)
  );

  tdr_node #(.W(W)) u_node (
    .prev(fed_back), .sample(u_hold), .eta(eta_q), .fb(fb_q),
    .clip(clip_q), .neg(mask_q[slot]), .x(node_x)
  );

  tdr_readout #(.NODES(NODES), .W(W)) u_readout (
    .clk(clk), .rst_n(rst_n), .step(step), .first(first), .last(last),
    .x(node_x), .weight($signed(w_q[slot])),
    .out_valid(out_valid), .out_data(out_data)
  );

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> !in_ready); // R1

  AST_OUT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2

  AST_OUT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(step) && $past(last) && in_ready)); // R2

  AST_NODE_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ((node_x <= clip_q) && (node_x >= -clip_q))); // R5

endmodule

// File: tb/tb_tdr_reservoir_core.sv
module tb_tdr_reservoir_core;
  localparam int N     = 8;
  localparam int W     = 16;
  localparam int FBL   = 31744;
  localparam int IDX_W = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [W-1:0] cfg_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;

  int total = 0;
  int bad = 0;
  int expq[$];
  int hist[$];
  int m_eta = 0, m_fb = 0, m_clip = 32767;
  int m_mask[N];
  int m_w[N];

  always #5 clk = ~clk;

  tdr_reservoir_core #(.NODES(N), .W(W), .FB_LIMIT(FBL)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // Monitor: every output pulse is compared with the oldest expected item. R2 R7
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (expq.size() == 0) check("R2 unexpected output", 1, 0);
        else check("R7 readout value", int'($signed(out_data)), expq.pop_front());
      end
    end
  end

  function automatic int s16(input int v);
    logic [15:0] t;
    t = v[15:0];
    return int'($signed(t));
  endfunction

  // Config write, issued only while idle; the model follows R5 R6 R8.
  task automatic cfg(input int sel, input int idx, input int data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel[2:0]; cfg_idx = idx[IDX_W-1:0]; cfg_data = data[15:0];
    @(negedge clk);
    cfg_wr = 1'b0;
    case (sel)
      0: m_eta = s16(data);
      1: begin
        m_fb = s16(data);
        if (m_fb > FBL) m_fb = FBL;
        if (m_fb < -FBL) m_fb = -FBL;
      end
      2: m_clip = data & 32'h7FFF;
      3: m_mask[idx] = data & 1;
      4: m_w[idx] = s16(data);
      default: ;
    endcase
  endtask

  // Driver: computes the expected readout (R3 R4 R5 R7), pushes it, sends the
  // sample and checks the handshake and output timing (R1 R2).
  task automatic send(input int u, input bit poke);
    longint acc = 0;
    longint y;
    for (int n = 0; n < N; n++) begin
      int prev, ft, it, s, x;
      prev = (hist.size() == N + 1) ? hist[0] : 0;
      ft = (m_fb * prev) >>> 15;
      it = (m_eta * u) >>> 15;
      if (m_mask[n] != 0) it = -it;
      s = ft + it;
      x = (s > m_clip) ? m_clip : ((s < -m_clip) ? -m_clip : s);
      hist.push_back(x);
      if (hist.size() > N + 1) void'(hist.pop_front());
      acc += longint'(m_w[n]) * longint'(x);
    end
    y = acc >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    expq.push_back(int'(y));

    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = u[15:0];
    @(negedge clk);
    in_valid = 1'b0; in_data = 16'h5A5A;
    for (int i = 0; i < N; i++) begin
      if (i > 0) @(negedge clk);
      check("R1 ready low while busy", int'(in_ready), 0);
      if (i < N - 1) check("R2 no early output", int'(out_valid), 0);
      if (poke && i == 1) begin
        cfg_wr = 1'b1; cfg_sel = 3'd4; cfg_idx = '0; cfg_data = 16'h7FFF;
      end
      if (poke && i == 2) begin
        cfg_sel = 3'd0; cfg_data = 16'h8000;
      end
      if (poke && i == 3) cfg_wr = 1'b0;
    end
    @(negedge clk);
    check("R1 ready back after N cycles", int'(in_ready), 1);
    check("R2 output one cycle after last slot", int'(out_valid), 1);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_mask[i] = 0; m_w[i] = 0; end
    repeat (4) @(negedge clk);
    check("R9 reset ready", int'(in_ready), 1);
    check("R9 reset out_valid", int'(out_valid), 0);
    check("R9 reset out_data", int'(out_data), 0);
    rst_n = 1'b1;
    send(16'h4000, 1'b0);            // R9: zero weights give zero

    // Main pattern: mixed mask, alternating weights. R3 R4
    cfg(0, 0, 16'h4000);
    cfg(1, 0, 16'h6000);
    for (int n = 0; n < N; n++) begin
      cfg(3, n, (8'hB2 >> n) & 1);
      cfg(4, n, (n % 2 == 0) ? 4096 * (n + 1) : -4096 * (n + 1));
    end
    cfg(7, 0, 16'h1234);             // R8: unused select ignored
    send(16'h2000, 1'b0);
    send(16'h2000, 1'b0);
    send(-16'sd12288, 1'b0);
    send(16'h7FFF, 1'b0);
    for (int k = 0; k < 3; k++) send(0, 1'b0);   // R4: decay through feedback
    send(-32768, 1'b0);

    // Clip at a small limit. R5
    cfg(2, 0, 16'h0800);
    send(16'h7000, 1'b0);
    send(-16'sd28672, 1'b0);
    send(16'h0100, 1'b0);

    // Feedback clamp at both signs. R6
    cfg(2, 0, 16'h7FFF);
    cfg(1, 0, 16'h7FFF);
    cfg(0, 0, 16'h7FFF);
    for (int k = 0; k < 3; k++) send(16'h7FFF, 1'b0);
    cfg(1, 0, 16'h8000);
    for (int k = 0; k < 3; k++) send(16'h6000, 1'b0);

    // Writes while busy are dropped. R8
    send(16'h3000, 1'b1);
    send(16'h3000, 1'b0);

    // Readout saturation at both rails. R7
    cfg(1, 0, 0);
    for (int n = 0; n < N; n++) begin cfg(3, n, 0); cfg(4, n, 16'h7FFF); end
    send(16'h7FFF, 1'b0);
    for (int n = 0; n < N; n++) cfg(3, n, 1);
    send(16'h7FFF, 1'b0);

    repeat (4) @(negedge clk);
    check("R2 all results delivered", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule